// File: doc/BRIEF.md
# Scan Chain Test Sequencer

This block is a small register-to-register datapath whose flip-flops are scan cells, stitched into several parallel chains of equal length, plus an on-chip sequencer that drives a structural test of that datapath. When a test starts, the sequencer fills every chain with stimulus from the tester pins. It then gives the datapath exactly one functional clock, so the flops catch the combinational response. After that it shifts the response out. Each unload cycle is also a load cycle for the next pattern. Every bit that leaves the chains during an unload is compared with the expected value on the tester pins. Any mismatch raises a sticky fail flag and adds to a saturating error count.

The same chains serve debug. While the datapath runs in functional mode it can be halted at any cycle. Once halted, the whole internal state can be read out through the scan outputs without loss, because each chain's output is fed back into its own input. A chosen state can also be shifted in from the tester pins. Releasing the halt resumes functional operation from whatever state the chains hold.

The controller has five states. IDLE is functional mode. SHIFT is a scan shift of the test. CAPTURE is the single functional test clock. HALT is debug freeze. DSHIFT is a debug shift. Transitions: IDLE to SHIFT on start, IDLE to HALT on a halt request, SHIFT to CAPTURE when a chain length of shifts ends with patterns still to capture, SHIFT to IDLE when it ends with none left, CAPTURE to SHIFT always, HALT to DSHIFT on a dump or preload request, DSHIFT to HALT after a chain length of shifts, and HALT to IDLE when the halt request drops.

Top module: `scan_test_seq`

## Requirements
- R1: After reset all state bits are 0, the controller is in IDLE, and scan_en, capture, busy, halted, fail and errcnt are all 0.
- R2: The state is a vector W of NCH*LEN bits. Chain c, cell k is bit c*LEN+k, and cell 0 is the chain head. In IDLE with func_en high, each clock loads W with W rotated left by one bit, XOR pi repeated NCH times. With func_en low, W holds.
- R3: po equals W[LEN-1:0] XOR W[NCH*LEN-1 -: LEN] in every state.
- R4: On each shift cycle (scan_en high), cell 0 of chain c takes the chain's scan input and cell k takes cell k-1. so[c] always shows cell LEN-1 of chain c.
- R5: A tst_start pulse in IDLE runs LEN SHIFT cycles. Then, for each of tst_npat patterns, it runs one CAPTURE cycle followed by LEN SHIFT cycles, and returns to IDLE. busy is high for exactly (tst_npat+1)*LEN+tst_npat cycles. A start while busy is ignored.
- R6: The CAPTURE cycle applies the R2 functional update once, using the pi present in that cycle.
- R7: On every SHIFT cycle except those of the first load, each bit so[c] is compared with tst_exp[c]. Each differing bit adds one to errcnt, which saturates at 2^ECW-1, and sets fail. Both stay until the next accepted start clears them.
- R8: dbg_halt in IDLE enters HALT, where the state holds whatever func_en does. Dropping dbg_halt in HALT returns to IDLE.
- R9: dbg_dump in HALT runs LEN DSHIFT cycles, feeding so[c] back into chain c. The state afterwards equals the state before.
- R10: dbg_load (when dbg_dump is low) in HALT runs LEN DSHIFT cycles fed from tst_si. The bit driven in the i-th cycle ends in cell LEN-1-i.
- R11: In IDLE, tst_start takes priority over dbg_halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| func_en | input | 1 | Functional clock enable in IDLE |
| pi | input | LEN | Primary inputs to the datapath |
| po | output | LEN | Primary outputs of the datapath |
| tst_start | input | 1 | Start a test run |
| tst_npat | input | PCW | Number of patterns to capture |
| tst_si | input | NCH | Scan stimulus, one bit per chain |
| tst_exp | input | NCH | Expected scan output, one bit per chain |
| so | output | NCH | Scan output, last cell of each chain |
| scan_en | output | 1 | Chains are shifting this cycle |
| capture | output | 1 | Test capture cycle |
| busy | output | 1 | Test run in progress (SHIFT or CAPTURE) |
| halted | output | 1 | Debug freeze active (HALT or DSHIFT) |
| fail | output | 1 | Sticky mismatch flag |
| errcnt | output | ECW | Saturating mismatch count |
| dbg_halt | input | 1 | Halt request / hold |
| dbg_dump | input | 1 | Start a state-preserving dump |
| dbg_load | input | 1 | Start a preload from tst_si |

## Verification
The bench uses the default shape of 4 chains of 8 cells with an 8-bit pattern count and an 8-bit error counter. A 32-bit state is small enough for the behavioural model to track every bit each cycle. With an 8-bit counter, a run of nine all-wrong patterns (288 mismatches) drives errcnt into saturation. Chains of 8 keep dump and preload streams short enough to compare bit by bit through so, and an 8-bit pattern count covers runs from zero patterns up to several overlapped ones.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_CAP,
        ST_HALT,
        ST_DSHIFT
    } seq_state_t;
endpackage

// File: rtl/scan_cells.sv
module scan_cells #(
    parameter int NCH = 4,
    parameter int LEN = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           se,
    input  logic           upd,
    input  logic [NCH-1:0] si,
    input  logic [LEN-1:0] pi,
    output logic [NCH-1:0] so,
    output logic [LEN-1:0] po
);
    localparam int NB = NCH * LEN;

    logic [NB-1:0] w;
    logic [NB-1:0] w_shift;
    logic [NB-1:0] w_func;

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_chain
            assign w_shift[c*LEN +: LEN] = {w[c*LEN +: LEN-1], si[c]};
            assign so[c] = w[c*LEN + LEN - 1];
        end
    endgenerate

    assign w_func = {w[NB-2:0], w[NB-1]} ^ {NCH{pi}};
    assign po = w[LEN-1:0] ^ w[NB-1 -: LEN];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    w <= '0;
        else if (se)   w <= w_shift;
        else if (upd)  w <= w_func;
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!se && !upd) |=> $stable(w));
endmodule

// File: rtl/scan_cmp.sv
module scan_cmp #(
    parameter int NCH = 4,
    parameter int ECW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           en,
    input  logic [NCH-1:0] so,
    input  logic [NCH-1:0] expv,
    output logic           fail,
    output logic [ECW-1:0] errcnt
);
    localparam int EW = ECW + 1;
    localparam logic [EW-1:0] EMAX = {1'b0, {ECW{1'b1}}};

    logic [EW-1:0] add;
    logic [EW-1:0] sum;

    always_comb begin
        add = '0;
        for (int c = 0; c < NCH; c++) add = add + EW'(so[c] ^ expv[c]);
        sum = {1'b0, errcnt} + add;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail   <= 1'b0;
            errcnt <= '0;
        end else if (clr) begin
            fail   <= 1'b0;
            errcnt <= '0;
        end else if (en && add != '0) begin
            fail   <= 1'b1;
            errcnt <= (sum > EMAX) ? EMAX[ECW-1:0] : sum[ECW-1:0];
        end
    end

    p_fail_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !clr) |=> fail);
    p_err_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> errcnt >= $past(errcnt));
endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
    import scan_pkg::*;
#(
    parameter int LEN = 8,
    parameter int PCW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           func_en,
    input  logic           start,
    input  logic [PCW-1:0] npat,
    input  logic           halt,
    input  logic           dump,
    input  logic           load,
    output logic           se,
    output logic           upd,
    output logic           recirc,
    output logic           cmp_en,
    output logic           clr,
    output logic           capture,
    output logic           busy,
    output logic           halted
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] CLAST = CW'(LEN - 1);

    seq_state_t     state;
    logic [CW-1:0]  cnt;
    logic [PCW-1:0] rem;
    logic           first;
    logic           rec_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            rem   <= '0;
            first <= 1'b0;
            rec_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_SHIFT;
                        cnt   <= '0;
                        rem   <= npat;
                        first <= 1'b1;
                    end else if (halt) begin
                        state <= ST_HALT;
                    end
                end
                ST_SHIFT: begin
                    if (cnt == CLAST) begin
                        cnt   <= '0;
                        state <= (rem != '0) ? ST_CAP : ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_CAP: begin
                    rem   <= rem - 1'b1;
                    first <= 1'b0;
                    state <= ST_SHIFT;
                end
                ST_HALT: begin
                    if (dump || load) begin
                        state <= ST_DSHIFT;
                        cnt   <= '0;
                        rec_q <= dump;
                    end else if (!halt) begin
                        state <= ST_IDLE;
                    end
                end
                ST_DSHIFT: begin
                    if (cnt == CLAST) begin
                        cnt   <= '0;
                        state <= ST_HALT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        se      = 1'b0;
        upd     = 1'b0;
        recirc  = 1'b0;
        cmp_en  = 1'b0;
        clr     = 1'b0;
        capture = 1'b0;
        busy    = 1'b0;
        halted  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                upd = func_en;
                clr = start;
            end
            ST_SHIFT: begin
                se     = 1'b1;
                busy   = 1'b1;
                cmp_en = !first;
            end
            ST_CAP: begin
                upd     = 1'b1;
                capture = 1'b1;
                busy    = 1'b1;
            end
            ST_HALT: halted = 1'b1;
            ST_DSHIFT: begin
                se     = 1'b1;
                halted = 1'b1;
                recirc = rec_q;
            end
            default: ;
        endcase
    end

    p_cap_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (se && !capture));
    p_cap_after_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(capture) |-> $past(se));
    p_halt_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !upd);
    p_modes_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, halted}));
endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq #(
    parameter int NCH = 4,
    parameter int LEN = 8,
    parameter int PCW = 8,
    parameter int ECW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           func_en,
    input  logic [LEN-1:0] pi,
    output logic [LEN-1:0] po,
    input  logic           tst_start,
    input  logic [PCW-1:0] tst_npat,
    input  logic [NCH-1:0] tst_si,
    input  logic [NCH-1:0] tst_exp,
    output logic [NCH-1:0] so,
    output logic           scan_en,
    output logic           capture,
    output logic           busy,
    output logic           halted,
    output logic           fail,
    output logic [ECW-1:0] errcnt,
    input  logic           dbg_halt,
    input  logic           dbg_dump,
    input  logic           dbg_load
);
    logic           upd;
    logic           recirc;
    logic           cmp_en;
    logic           clr;
    logic [NCH-1:0] cell_si;

    assign cell_si = recirc ? so : tst_si;

    scan_fsm #(.LEN(LEN), .PCW(PCW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .func_en(func_en),
        .start(tst_start), .npat(tst_npat),
        .halt(dbg_halt), .dump(dbg_dump), .load(dbg_load),
        .se(scan_en), .upd(upd), .recirc(recirc), .cmp_en(cmp_en),
        .clr(clr), .capture(capture), .busy(busy), .halted(halted)
    );

    scan_cells #(.NCH(NCH), .LEN(LEN)) u_cells (
        .clk(clk), .rst_n(rst_n), .se(scan_en), .upd(upd),
        .si(cell_si), .pi(pi), .so(so), .po(po)
    );

    scan_cmp #(.NCH(NCH), .ECW(ECW)) u_cmp (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(cmp_en),
        .so(so), .expv(tst_exp), .fail(fail), .errcnt(errcnt)
    );

    p_start_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !halted && tst_start) |=> busy);
endmodule

// File: tb/tb_scan_test_seq.sv
module tb_scan_test_seq;
    localparam int NCH = 4;
    localparam int LEN = 8;
    localparam int NB  = NCH * LEN;
    localparam int EMAX = 255;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           func_en = 1'b0;
    logic [LEN-1:0] pi = '0;
    logic [LEN-1:0] po;
    logic           tst_start = 1'b0;
    logic [7:0]     tst_npat = '0;
    logic [NCH-1:0] tst_si = '0;
    logic [NCH-1:0] tst_exp = '0;
    logic [NCH-1:0] so;
    logic           scan_en, capture, busy, halted, fail;
    logic [7:0]     errcnt;
    logic           dbg_halt = 1'b0, dbg_dump = 1'b0, dbg_load = 1'b0;

    always #4 clk = ~clk;

    scan_test_seq dut (
        .clk(clk), .rst_n(rst_n), .func_en(func_en), .pi(pi), .po(po),
        .tst_start(tst_start), .tst_npat(tst_npat), .tst_si(tst_si),
        .tst_exp(tst_exp), .so(so), .scan_en(scan_en), .capture(capture),
        .busy(busy), .halted(halted), .fail(fail), .errcnt(errcnt),
        .dbg_halt(dbg_halt), .dbg_dump(dbg_dump), .dbg_load(dbg_load)
    );

    int tests = 0;
    int fails = 0;

    task automatic check(input string req, input string what, input longint act, input longint expv);
        tests++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Behavioural reference: per-chain bit arrays and a mode integer
    // 0 idle, 1 test shift, 2 capture, 3 frozen, 4 debug shift
    bit m [NCH][LEN];
    int ms = 0, mcnt = 0, mrem = 0, mrec = 0, merr = 0;
    bit mfirst = 0, mfail = 0;

    function automatic bit mbit(input int n);
        return m[n / LEN][n % LEN];
    endfunction

    function automatic logic [NCH-1:0] m_so();
        logic [NCH-1:0] r;
        for (int c = 0; c < NCH; c++) r[c] = m[c][LEN-1];
        return r;
    endfunction

    function automatic logic [LEN-1:0] m_po();
        logic [LEN-1:0] r;
        for (int k = 0; k < LEN; k++) r[k] = mbit(k) ^ mbit(NB - LEN + k);
        return r;
    endfunction

    task automatic m_func();
        bit nx [NB];
        for (int n = 0; n < NB; n++) nx[n] = mbit((n + NB - 1) % NB) ^ pi[n % LEN];
        for (int n = 0; n < NB; n++) m[n / LEN][n % LEN] = nx[n];
    endtask

    task automatic m_shift(input logic [NCH-1:0] in);
        for (int c = 0; c < NCH; c++) begin
            for (int k = LEN - 1; k > 0; k--) m[c][k] = m[c][k-1];
            m[c][0] = in[c];
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) for (int k = 0; k < LEN; k++) m[c][k] = 0;
            ms = 0; mcnt = 0; mrem = 0; mrec = 0; merr = 0; mfirst = 0; mfail = 0;
        end else begin
            logic [NCH-1:0] cur;
            cur = m_so();
            case (ms)
                0: begin
                    if (func_en) m_func();
                    if (tst_start) begin
                        ms = 1; mcnt = 0; mrem = tst_npat; mfirst = 1; mfail = 0; merr = 0;
                    end else if (dbg_halt) ms = 3;
                end
                1: begin
                    if (!mfirst)
                        for (int c = 0; c < NCH; c++)
                            if (cur[c] != tst_exp[c]) begin
                                mfail = 1;
                                if (merr < EMAX) merr++;
                            end
                    m_shift(tst_si);
                    if (mcnt == LEN - 1) begin mcnt = 0; ms = (mrem != 0) ? 2 : 0; end
                    else mcnt++;
                end
                2: begin m_func(); mrem--; mfirst = 0; ms = 1; end
                3: begin
                    if (dbg_dump || dbg_load) begin ms = 4; mcnt = 0; mrec = dbg_dump; end
                    else if (!dbg_halt) ms = 0;
                end
                default: begin
                    m_shift(mrec ? cur : tst_si);
                    if (mcnt == LEN - 1) begin mcnt = 0; ms = 3; end
                    else mcnt++;
                end
            endcase
        end
    end

    // Per-cycle comparison against the reference, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R4", "so", so, m_so());
            check("R3", "po", po, m_po());
            check("R5", "scan_en", scan_en, (ms == 1 || ms == 4));
            check("R5", "capture", capture, ms == 2);
            check("R5", "busy", busy, (ms == 1 || ms == 2));
            check("R8", "halted", halted, (ms == 3 || ms == 4));
            check("R7", "fail", fail, mfail);
            check("R7", "errcnt", errcnt, merr);
        end
    end

    task automatic run_test(input int np, input int mode); // mode 0 good, 1 all wrong, 2 one wrong unload
        int cyc = 0;
        int shifts = 0;
        @(negedge clk);
        tst_start = 1'b1; tst_npat = 8'(np);
        @(negedge clk);
        tst_start = 1'b0;
        while (busy) begin
            logic [NCH-1:0] e;
            e = m_so();
            if (mode == 1) e = ~e;
            if (mode == 2 && ms == 1 && !mfirst && shifts == LEN + 3) e[1] = ~e[1];
            if (ms == 1) shifts++;
            tst_exp = e;
            tst_si = NCH'($urandom);
            pi = LEN'($urandom);
            if (cyc == 5) tst_start = 1'b1;   // ignored while busy
            else tst_start = 1'b0;
            cyc++;
            @(negedge clk);
        end
        tst_start = 1'b0;
        check("R5", "busy cycles", cyc, (np + 1) * LEN + np);
    endtask

    task automatic dump_stream(output logic [NCH-1:0] st [LEN]);
        @(negedge clk);
        dbg_dump = 1'b1;
        @(negedge clk);
        dbg_dump = 1'b0;
        for (int i = 0; i < LEN; i++) begin
            st[i] = so;
            tst_si = NCH'($urandom);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [NCH-1:0] s1 [LEN];
        logic [NCH-1:0] s2 [LEN];
        logic [NCH-1:0] pat [LEN];
        logic [LEN-1:0] po_hold;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "so", so, 0);
        check("R1", "po", po, 0);
        check("R1", "status", {scan_en, capture, busy, halted, fail}, 0);
        check("R1", "errcnt", errcnt, 0);

        // R2 functional run
        func_en = 1'b1;
        for (int i = 0; i < 20; i++) begin
            pi = LEN'($urandom);
            @(negedge clk);
        end
        func_en = 1'b0;
        po_hold = po;
        repeat (3) @(negedge clk);
        check("R2", "po held with func_en low", po, po_hold);
        check("R2", "po after functional run", po, m_po());

        // R5/R6 good run, several patterns
        run_test(3, 0);
        check("R6", "fail after good run", fail, 0);
        check("R6", "errcnt after good run", errcnt, 0);
        // zero patterns: one uncompared load
        run_test(0, 1);
        check("R7", "first load not compared", errcnt, 0);
        // single mismatched bit
        run_test(2, 2);
        check("R7", "one mismatch", errcnt, 1);
        check("R7", "fail set", fail, 1);
        // saturation
        run_test(9, 1);
        check("R7", "errcnt saturates", errcnt, EMAX);
        run_test(1, 0);
        check("R7", "start clears fail", fail, 0);

        // R11 start beats halt
        @(negedge clk);
        dbg_halt = 1'b1; tst_start = 1'b1; tst_npat = 8'd0;
        @(negedge clk);
        tst_start = 1'b0; dbg_halt = 1'b0;
        check("R11", "busy not halted", {busy, halted}, 2'b10);
        while (busy) @(negedge clk);

        // R8 halt freezes state
        func_en = 1'b1;
        repeat (4) begin pi = LEN'($urandom); @(negedge clk); end
        dbg_halt = 1'b1;
        @(negedge clk);
        check("R8", "halted", halted, 1);
        po_hold = po;
        repeat (5) begin pi = LEN'($urandom); @(negedge clk); end
        check("R8", "po frozen", po, po_hold);

        // R9 dump twice, streams equal and state kept
        dump_stream(s1);
        check("R9", "po after dump", po, po_hold);
        dump_stream(s2);
        for (int i = 0; i < LEN; i++) check("R9", "dump stream repeat", s2[i], s1[i]);

        // R10 preload then dump
        for (int i = 0; i < LEN; i++) pat[i] = NCH'($urandom);
        @(negedge clk);
        dbg_load = 1'b1;
        @(negedge clk);
        dbg_load = 1'b0;
        for (int i = 0; i < LEN; i++) begin
            tst_si = pat[i];
            @(negedge clk);
        end
        dump_stream(s1);
        for (int i = 0; i < LEN; i++) check("R10", "preloaded stream", s1[i], pat[i]);

        // R8 resume
        dbg_halt = 1'b0;
        @(negedge clk);
        check("R8", "resumed", halted, 0);
        repeat (4) begin pi = LEN'($urandom); @(negedge clk); end
        func_en = 1'b0;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule